// File: doc/BRIEF.md
# Centered PWM Compare Unit with Direction-Qualified Sync

This block is one slice of a power-stage PWM timer. A 12-bit counter runs in centered fashion: it climbs from zero to a programmable top value, then falls back to zero, and repeats. A direction flag marks which half-period is in progress. Four 12-bit compare registers, called RA, RB, SA and SB here, are checked against the counter on every cycle. Each equality produces a one-cycle compare pulse. Two waveform outputs are built from these matches.

Software loads the compare registers over an 8-bit bus. A write to the high-byte address only parks the value in a single temporary latch, which all four registers share. The following low-byte write commits that latch and the low byte into the addressed register in one cycle. The register therefore never holds a half-updated value.

A 2-bit selector decides whether a synchronization pulse is emitted on the RA match. The pulse can be taken on the rising half, on the falling half, or never.

Top module: `pwm_center_cmp`

## Requirements
- R1: While rst_ni is low, and right after it is released, all four compare registers read zero. The counter is 0, the direction flag is 0 (counting up), and the match, sync and waveform outputs are 0.
- R2: A write whose address has bit 0 set (high byte) changes none of the four compare registers. It only loads the temporary latch.
- R3: A write whose address has bit 0 clear (low byte) loads the addressed register with {latch[3:0], data} in one cycle. The latch is shared, so a high-byte write to one register's address can be committed by a low-byte write to another register. Address bits 2:1 select the register: 0 for RA, 1 for RB, 2 for SA, 3 for SB.
- R4: Reads are combinational on rd_addr_i. A high-byte read returns the register's bits 11:8 in bits 3:0, with bits 7:4 read as zero. A low-byte read returns bits 7:0.
- R5: While the flag is 0 and the counter is below top_i, the counter increments. While the flag is 0 and the counter is at or above top, the flag goes to 1 and the counter decrements (it stays at 0 if it is already 0). While the flag is 1 and the counter is non-zero, the counter decrements. While the flag is 1 and the counter is 0, the flag returns to 0 and the counter moves to 1 (or stays at 0 when top is 0).
- R6: match_o[i] is 1 in the cycle after the counter equals register i. The bit order is RA=0, RB=1, SA=2, SB=3.
- R7: With sync select 00, sync_o pulses in the cycle after an RA match that occurs with the direction flag at 1 (counting down).
- R8: With sync select 01, sync_o pulses in the cycle after an RA match that occurs with the direction flag at 0 (counting up).
- R9: With sync select 10 or 11, sync_o stays 0.
- R10: When RA is 0, sync_o stays 0 for every select value.
- R11: out_a_o is set after an SA match while counting up and cleared after an RA match while counting down. out_b_o works the same way with SB and RB. Otherwise each output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 3 | Write address: bits 2:1 select the register, bit 0 set selects the high byte |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address, same encoding as the write address |
| rd_data_o | output | 8 | Read data |
| top_i | input | 12 | Counter turn-around value |
| sync_sel_i | input | 2 | Sync source select |
| cnt_o | output | 12 | Counter value |
| dir_down_o | output | 1 | Direction flag, 1 while counting down |
| match_o | output | 4 | Compare pulses, ordered RA, RB, SA, SB |
| sync_o | output | 1 | Synchronization pulse |
| out_a_o | output | 1 | Waveform A |
| out_b_o | output | 1 | Waveform B |

## Verification
Each sync select value is exercised with the same compare settings. This separates an RA match on the rising half from one on the falling half, and from no pulse at all. RA is also set to 0 under both pulsing selects. The top value is varied, including a value below the current count and top zero, so the turn-around conditions at both ends of the count are exercised. A high-byte write that is never committed, and a latch committed into a different register, show whether the high byte is staged and whether the latch is shared. Read-back sweeps the address on every cycle, which covers the zeroed upper nibble.

// File: rtl/pwm_cc_pkg.sv
package pwm_cc_pkg;
  localparam int NUM_CMP = 4;
  typedef enum logic [1:0] {
    CMP_RA = 2'd0,
    CMP_RB = 2'd1,
    CMP_SA = 2'd2,
    CMP_SB = 2'd3
  } cmp_idx_e;
  typedef enum logic [1:0] {
    SYNC_ON_DOWN = 2'b00,
    SYNC_ON_UP   = 2'b01,
    SYNC_NONE_A  = 2'b10,
    SYNC_NONE_B  = 2'b11
  } sync_sel_e;
endpackage

// File: rtl/pwm_cc_regs.sv
module pwm_cc_regs #(
  parameter int CNT_W   = 12,
  parameter int BUS_W   = 8,
  parameter int NUM_CMP = 4,
  localparam int HI_W   = CNT_W - BUS_W,
  localparam int IDX_W  = $clog2(NUM_CMP),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [BUS_W-1:0]                  wr_data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [BUS_W-1:0]                  rd_data_o,
  output logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_o
);
  // only the bits that reach a register are kept in the shared latch
  logic [HI_W-1:0] tmp_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic wr_hi, wr_lo;

  assign wr_hi = wr_en_i &  wr_addr_i[0];
  assign wr_lo = wr_en_i & ~wr_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tmp_q <= '0;
    else if (wr_hi) tmp_q <= wr_data_i[HI_W-1:0];
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_q[i] <= '0;
      else if (wr_lo && (wr_addr_i[ADDR_W-1:1] == IDX_W'(i)))
        cmp_q[i] <= {tmp_q, wr_data_i};
    end
  end

  logic [CNT_W-1:0] rd_sel;
  assign rd_sel    = cmp_q[rd_addr_i[ADDR_W-1:1]];
  assign rd_data_o = rd_addr_i[0] ? BUS_W'(rd_sel[CNT_W-1:BUS_W]) : rd_sel[BUS_W-1:0];
  assign cmp_o     = cmp_q;
endmodule

// File: rtl/pwm_cc_counter.sv
module pwm_cc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (!dir_q) begin
      if (cnt_q >= top_i) begin
        dir_q <= 1'b1;
        cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        dir_q <= 1'b0;
        cnt_q <= (top_i == '0) ? '0 : CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
endmodule

// File: rtl/pwm_cc_match.sv
module pwm_cc_match
  import pwm_cc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int NUM_OUT = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic                          dir_down_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_i,
  input  logic [1:0]                    sync_sel_i,
  output logic [NUM_CMP-1:0]            match_o,
  output logic                          sync_o,
  output logic [NUM_OUT-1:0]            wave_o
);
  logic [NUM_CMP-1:0] eq;
  logic [NUM_CMP-1:0] match_q;
  logic sync_q, sync_d, ra_hit;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_eq
    assign eq[i] = (cnt_i == cmp_i[i]);
  end

  // zero RA never qualifies as a sync source
  assign ra_hit = eq[CMP_RA] && (cmp_i[CMP_RA] != '0);

  always_comb begin
    unique case (sync_sel_e'(sync_sel_i))
      SYNC_ON_DOWN: sync_d = ra_hit &&  dir_down_i;
      SYNC_ON_UP:   sync_d = ra_hit && !dir_down_i;
      default:      sync_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      sync_q  <= 1'b0;
    end else begin
      match_q <= eq;
      sync_q  <= sync_d;
    end
  end

  // channel k: set by compare 2+k rising, cleared by compare k falling
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_wave
    logic wave_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          wave_q <= 1'b0;
      else if (eq[2+k] && !dir_down_i)      wave_q <= 1'b1;
      else if (eq[k] && dir_down_i)         wave_q <= 1'b0;
    end
    assign wave_o[k] = wave_q;
  end

  assign match_o = match_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/pwm_center_cmp.sv
module pwm_center_cmp
  import pwm_cc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int BUS_W   = 8,
  localparam int ADDR_W = $clog2(NUM_CMP) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0]  rd_data_o,
  input  logic [CNT_W-1:0]  top_i,
  input  logic [1:0]        sync_sel_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_down_o,
  output logic [NUM_CMP-1:0] match_o,
  output logic              sync_o,
  output logic              out_a_o,
  output logic              out_b_o
);
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_w;
  logic [1:0] wave_w;

  pwm_cc_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .NUM_CMP(NUM_CMP)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .cmp_o(cmp_w)
  );

  pwm_cc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .top_i, .cnt_o, .dir_down_o
  );

  pwm_cc_match #(.CNT_W(CNT_W), .NUM_OUT(2)) u_match (
    .clk_i, .rst_ni, .cnt_i(cnt_o), .dir_down_i(dir_down_o), .cmp_i(cmp_w),
    .sync_sel_i, .match_o, .sync_o, .wave_o(wave_w)
  );

  assign out_a_o = wave_w[0];
  assign out_b_o = wave_w[1];
endmodule

// File: rtl/pwm_center_cmp_chk.sv
module pwm_center_cmp_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             dir_down_i,
  input logic [CNT_W-1:0] top_i,
  input logic [1:0]       sync_sel_i,
  input logic [CNT_W-1:0] ra_i,
  input logic [3:0]       match_i,
  input logic             sync_i
);
  // R5
  cnt_up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_down_i && cnt_i < top_i) |=> (cnt_i == $past(cnt_i) + 1'b1));
  // R5
  cnt_down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_down_i && cnt_i != '0) |=> (dir_down_i && cnt_i == $past(cnt_i) - 1'b1));
  // R6
  ra_match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == ra_i) |=> match_i[0]);
  // R7
  sync_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'b00 && ra_i != '0 && cnt_i == ra_i && dir_down_i) |=> sync_i);
  // R8
  sync_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'b01 && ra_i != '0 && cnt_i == ra_i && !dir_down_i) |=> sync_i);
  // R9
  sync_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_sel_i[1] |=> !sync_i);
  // R10
  sync_ra_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |=> !sync_i);
endmodule

bind pwm_center_cmp pwm_center_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_o), .dir_down_i(dir_down_o),
  .top_i(top_i), .sync_sel_i(sync_sel_i), .ra_i(cmp_w[0]), .match_i(match_o),
  .sync_i(sync_o)
);

// File: tb/sim_pwm_center_cmp.sv
module sim_pwm_center_cmp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] top = 12'd10;
  logic [1:0] sel = 2'b00;
  logic [7:0] rd_data;
  logic [11:0] cnt;
  logic dir_down, sync, out_a, out_b;
  logic [3:0] match;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_dir = 0, m_tmp = 0, m_sync = 0, m_oa = 0, m_ob = 0;
  int m_cmp[4] = '{0, 0, 0, 0};
  int m_match[4] = '{0, 0, 0, 0};
  int sync_seen = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_center_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .top_i(top),
    .sync_sel_i(sel), .cnt_o(cnt), .dir_down_o(dir_down), .match_o(match),
    .sync_o(sync), .out_a_o(out_a), .out_b_o(out_b)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic string sync_tag();
    if (m_cmp[0] == 0) return "R10";
    if (sel == 2'b00) return "R7";
    if (sel == 2'b01) return "R8";
    return "R9";
  endfunction

  // compare all outputs, then apply new inputs and advance the model by one edge
  task automatic step(bit we, int wa, int wd);
    int exp_rd, reg_v;
    int eq[4];
    int n_cnt, n_dir;
    reg_v  = m_cmp[rd_addr >> 1];
    exp_rd = rd_addr[0] ? ((reg_v >> 8) & 'hF) : (reg_v & 'hFF);
    chk(rst_n ? "R2/R3/R4" : "R1", "rd_data", int'(rd_data), exp_rd);
    chk(rst_n ? "R5" : "R1", "cnt", int'(cnt), m_cnt);
    chk(rst_n ? "R5" : "R1", "dir", int'(dir_down), m_dir);
    for (int i = 0; i < 4; i++) chk(rst_n ? "R6" : "R1", "match", int'(match[i]), m_match[i]);
    chk(rst_n ? sync_tag() : "R1", "sync", int'(sync), m_sync);
    chk(rst_n ? "R11" : "R1", "out_a", int'(out_a), m_oa);
    chk(rst_n ? "R11" : "R1", "out_b", int'(out_b), m_ob);
    if (sync) sync_seen++;

    wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd);
    rd_addr = 3'(cyc % 8);
    cyc++;

    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_tmp = 0; m_sync = 0; m_oa = 0; m_ob = 0;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_match[i] = 0; end
    end else begin
      for (int i = 0; i < 4; i++) eq[i] = (m_cnt == m_cmp[i]) ? 1 : 0;
      for (int i = 0; i < 4; i++) m_match[i] = eq[i];
      m_sync = 0;
      if (eq[0] == 1 && m_cmp[0] != 0) begin
        if (sel == 2'b00 && m_dir == 1) m_sync = 1;
        if (sel == 2'b01 && m_dir == 0) m_sync = 1;
      end
      if (eq[2] == 1 && m_dir == 0) m_oa = 1; else if (eq[0] == 1 && m_dir == 1) m_oa = 0;
      if (eq[3] == 1 && m_dir == 0) m_ob = 1; else if (eq[1] == 1 && m_dir == 1) m_ob = 0;
      n_cnt = m_cnt; n_dir = m_dir;
      if (m_dir == 0) begin
        if (m_cnt >= int'(top)) begin n_dir = 1; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else n_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin n_dir = 0; n_cnt = (top == 0) ? 0 : 1; end
        else n_cnt = m_cnt - 1;
      end
      m_cnt = n_cnt; m_dir = n_dir;
      if (we) begin
        if (wa % 2 == 1) m_tmp = wd;
        else m_cmp[wa >> 1] = ((m_tmp & 'hF) << 8) | (wd & 'hFF);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  task automatic wr16(int idx, int val);
    step(1'b1, idx * 2 + 1, (val >> 8) & 'hFF);
    step(1'b1, idx * 2, val & 'hFF);
  endtask

  initial begin
    @(negedge clk);
    idle(3);                      // R1 reset state
    rst_n = 1'b1;
    idle(4);                      // R1 just after release
    wr16(0, 5); wr16(1, 8); wr16(2, 3); wr16(3, 2);
    sel = 2'b00; idle(50);        // R7
    sel = 2'b01; idle(50);        // R8
    sel = 2'b10; idle(30);        // R9
    sel = 2'b11; idle(30);        // R9
    step(1'b1, 1, 'hF7); idle(16); // R2 high write only, R4 upper nibble
    step(1'b1, 6, 'h09); idle(16); // R3 shared latch commits into SB
    wr16(0, 0);
    sel = 2'b00; idle(30);        // R10
    sel = 2'b01; idle(30);        // R10
    wr16(0, 'hFA7); wr16(1, 'h004); top = 12'd6; idle(40);
    wr16(0, 6); wr16(2, 6); sel = 2'b00; idle(40); // RA at top
    top = 12'd2; idle(20);        // R5 top below count
    top = 12'd0; idle(10);        // R5 top zero
    top = 12'd7; wr16(0, 1); sel = 2'b01; idle(40);
    chk("R8", "sync pulses seen", int'(sync_seen > 0), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule